// File: doc/BRIEF.md
# Per-Port Jabber Cutoff Controller

One instance of this block sits on each port of a repeater. It samples the port's carrier-sense input on every clock and counts how many samples in a row show carrier. When a burst runs past the allowed length, the port is treated as jabbering. The block then drops both the receive-enable gate and the transmit-enable gate of that port and raises a status flag. No other port is affected, because each port has its own instance and no state is shared between instances.

Recovery depends on a speed mode. In the 100 Mb/s mode there is no recovery timer. The port stays isolated for as long as carrier remains up. It returns to service only after a short run of idle samples. The legacy 10 Mb/s mode uses a longer burst limit and a longer required silence, which models the 5 ms stop and the 96 to 116 bit-time quiet gap. Every limit is a parameter given in clock cycles.

Top module: `jabber_guard`

## Requirements
- R1: With the 100 Mb/s mode in force (mode_i = 0), the port is cut off on the sample at which FAST_LIMIT+1 consecutive carrier-high samples have been seen. A burst of FAST_LIMIT samples or fewer never cuts it off.
- R2: With the 10 Mb/s mode in force (mode_i = 1), the same rule applies with SLOW_LIMIT in place of FAST_LIMIT.
- R3: rx_en_o and tx_en_o are always equal, and jabber_o is always their inverse. The gates are low, and the flag is high, exactly while the port is cut off.
- R4: While the port is cut off and carrier stays high, the cutoff holds for as long as the carrier lasts, with no time limit.
- R5: A cut-off port is released on the sample at which the number of consecutive carrier-low samples reaches FAST_QUIET in the 100 Mb/s mode, or SLOW_QUIET in the 10 Mb/s mode.
- R6: A carrier-high sample during the quiet wait keeps the port cut off and restarts the quiet count from zero.
- R7: A carrier-low sample before the limit clears the activity count, so separate bursts never add up.
- R8: The mode is captured from mode_i on the sample that starts a burst. It is held until the port is idle again, so a change of mode_i during a burst or during a cutoff has no effect on that episode.
- R9: After reset, both gates are high and jabber_o is low.
- R10: Outputs are registered. They change on the clock edge that takes the deciding carrier sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crs_i | input | 1 | Port carrier sense |
| mode_i | input | 1 | 0: 100 Mb/s cutoff, 1: 10 Mb/s timed recovery |
| rx_en_o | output | 1 | Receive path enable for the port |
| tx_en_o | output | 1 | Transmit path enable for the port |
| jabber_o | output | 1 | High while the port is cut off for jabber |

## Verification
The bench builds the block with FAST_LIMIT=6, SLOW_LIMIT=10, FAST_QUIET=2 and SLOW_QUIET=4. This keeps every burst and silence length short enough to sweep in full. In both modes it drives every burst length from one sample up to three samples past the limit. Each burst is followed by a silence longer than the quiet window, and all three outputs are checked on every sample against run-length arithmetic. Separate sequences cover the quiet count restarting when carrier returns, a mode change part way through a burst and a mode change while idle, plus two short bursts back to back to show that counts do not add up.

// File: rtl/jabber_guard_pkg.sv
package jabber_guard_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_CUT    = 2'd2,
    ST_QUIET  = 2'd3
  } jg_state_e;

  function automatic int unsigned jg_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/jg_run_counter.sv
module jg_run_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CntMax = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (inc_i && cnt_o != CntMax) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/jg_ctrl.sv
module jg_ctrl
  import jabber_guard_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned QW = 4,
  parameter int unsigned FAST_LIMIT = 6,
  parameter int unsigned SLOW_LIMIT = 10,
  parameter int unsigned FAST_QUIET = 2,
  parameter int unsigned SLOW_QUIET = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          crs_i,
  input  logic          mode_i,
  input  logic [AW-1:0] act_cnt_i,
  input  logic [QW-1:0] qt_cnt_i,
  output jg_state_e     state_o
);
  localparam logic [AW-1:0] FastLim = AW'(FAST_LIMIT);
  localparam logic [AW-1:0] SlowLim = AW'(SLOW_LIMIT);
  localparam logic [QW:0]   FastQt  = (QW+1)'(FAST_QUIET);
  localparam logic [QW:0]   SlowQt  = (QW+1)'(SLOW_QUIET);

  jg_state_e state_q, state_d;
  logic      mode_q;
  logic [AW-1:0] lim;
  logic [QW:0]   qt_need;
  logic          limit_hit, quiet_done;

  // mode follows the input only while idle; frozen for the whole episode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 mode_q <= 1'b0;
    else if (state_q == ST_IDLE) mode_q <= mode_i;
  end

  assign lim        = mode_q ? SlowLim : FastLim;
  assign qt_need    = mode_q ? SlowQt : FastQt;
  assign limit_hit  = (act_cnt_i >= lim);
  assign quiet_done = ({1'b0, qt_cnt_i} + 1'b1 >= qt_need);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (crs_i) state_d = ST_ACTIVE;
      ST_ACTIVE: if (!crs_i)        state_d = ST_IDLE;
                 else if (limit_hit) state_d = ST_CUT;
      ST_CUT:    if (!crs_i) state_d = quiet_done ? ST_IDLE : ST_QUIET;
      ST_QUIET:  if (crs_i)           state_d = ST_CUT;
                 else if (quiet_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard
  import jabber_guard_pkg::*;
#(
  parameter int unsigned FAST_LIMIT = 16375,
  parameter int unsigned SLOW_LIMIT = 125000,
  parameter int unsigned FAST_QUIET = 2,
  parameter int unsigned SLOW_QUIET = 240
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic crs_i,
  input  logic mode_i,
  output logic rx_en_o,
  output logic tx_en_o,
  output logic jabber_o
);
  localparam int unsigned AW = $clog2(jg_max(FAST_LIMIT, SLOW_LIMIT) + 2);
  localparam int unsigned QW = $clog2(jg_max(FAST_QUIET, SLOW_QUIET) + 2);

  jg_state_e     state;
  logic [AW-1:0] act_cnt;
  logic [QW-1:0] qt_cnt;
  logic          cut;

  assign cut = (state == ST_CUT) || (state == ST_QUIET);

  jg_run_counter #(.W(AW)) u_act_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!crs_i || cut),
    .inc_i  (crs_i),
    .cnt_o  (act_cnt)
  );

  jg_run_counter #(.W(QW)) u_qt_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crs_i || !cut),
    .inc_i  (!crs_i),
    .cnt_o  (qt_cnt)
  );

  jg_ctrl #(
    .AW(AW), .QW(QW),
    .FAST_LIMIT(FAST_LIMIT), .SLOW_LIMIT(SLOW_LIMIT),
    .FAST_QUIET(FAST_QUIET), .SLOW_QUIET(SLOW_QUIET)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .crs_i     (crs_i),
    .mode_i    (mode_i),
    .act_cnt_i (act_cnt),
    .qt_cnt_i  (qt_cnt),
    .state_o   (state)
  );

  assign rx_en_o  = !cut;
  assign tx_en_o  = !cut;
  assign jabber_o = cut;
endmodule

// File: rtl/jabber_guard_chk.sv
module jabber_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic crs_i,
  input logic rx_en_o,
  input logic tx_en_o,
  input logic jabber_o
);
  // R3: gates and flag move together
  p_gates_agree_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_o == tx_en_o) && (jabber_o == !rx_en_o));

  // R1/R2: cutoff only starts on a carrier-high sample
  p_cut_on_carrier_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_en_o) |-> $past(crs_i));

  // R4: carrier held high never releases a cut-off port
  p_hold_while_carrier_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_o && crs_i) |=> !rx_en_o);

  // R5: release only on an idle sample
  p_release_on_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_en_o) |-> !$past(crs_i));

  // R7: an idle sample while enabled cannot lead to a cutoff on the next edge
  p_idle_no_cut_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_o && !crs_i) |=> rx_en_o);
endmodule

bind jabber_guard jabber_guard_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .crs_i    (crs_i),
  .rx_en_o  (rx_en_o),
  .tx_en_o  (tx_en_o),
  .jabber_o (jabber_o)
);

// File: tb/jabber_guard_tb.sv
module jabber_guard_tb;
  localparam int FL = 6, SL = 10, FQ = 2, SQ = 4;

  logic clk = 1'b0, rst_n = 1'b0, crs = 1'b0, mode = 1'b0;
  logic rx_en, tx_en, jab;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  jabber_guard #(.FAST_LIMIT(FL), .SLOW_LIMIT(SL), .FAST_QUIET(FQ), .SLOW_QUIET(SQ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .crs_i(crs), .mode_i(mode),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .jabber_o(jab));

  task automatic check(input string req, input bit exp_cut);
    n_chk++;
    if (rx_en !== !exp_cut || tx_en !== !exp_cut || jab !== exp_cut) begin
      n_fail++;
      $display("FAIL %s: rx=%b tx=%b jab=%b expected rx=%b tx=%b jab=%b",
               req, rx_en, tx_en, jab, !exp_cut, !exp_cut, exp_cut);
    end
  endtask

  // drive one carrier sample, then look after the edge that takes it (R10)
  task automatic step(input bit c, input bit m, input string req, input bit exp_cut);
    @(negedge clk);
    crs  = c;
    mode = m;
    @(posedge clk);
    #1;
    check(req, exp_cut);
  endtask

  // burst of n highs then m lows from idle; expectation from run lengths
  task automatic burst(input bit md, input int n, input int m, input string req);
    int lim = md ? SL : FL;
    int q   = md ? SQ : FQ;
    for (int i = 1; i <= n; i++) step(1'b1, md, req, i > lim);
    for (int j = 1; j <= m; j++) step(1'b0, md, req, (n > lim) && (j < q));
  endtask

  initial begin
    #5;
    check("R9", 1'b0);
    #40 rst_n = 1'b1;
    step(1'b0, 1'b0, "R9", 1'b0);

    for (int n = 1; n <= FL + 3; n++) burst(1'b0, n, FQ + 2, "R1_R5");
    for (int n = 1; n <= SL + 3; n++) burst(1'b1, n, SQ + 2, "R2_R5");

    // R4: long carrier in 100M mode stays cut
    burst(1'b0, FL + 200, FQ + 1, "R4");

    // R7: two short bursts separated by one idle sample do not add up
    burst(1'b0, FL, 1, "R7");
    burst(1'b0, FL, 2, "R7");

    // R6: carrier during quiet wait restarts the count (slow mode)
    burst(1'b1, SL + 1, 0, "R6");
    for (int j = 1; j < SQ; j++) step(1'b0, 1'b1, "R6", 1'b1);
    for (int k = 0; k < 3; k++)  step(1'b1, 1'b1, "R6", 1'b1);
    for (int j = 1; j <= SQ + 1; j++) step(1'b0, 1'b1, "R6", j < SQ);

    // R8: burst starts fast; mode_i switched to slow mid-burst is ignored
    for (int i = 1; i <= FL + 2; i++) step(1'b1, i > 2, "R8", i > FL);
    for (int j = 1; j <= FQ + 1; j++) step(1'b0, 1'b1, "R8", j < FQ);
    // mode changed while idle takes effect on the next burst
    burst(1'b1, FL + 1, 1, "R8");
    burst(1'b1, SL + 1, SQ + 1, "R8");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule